// File: doc/BRIEF.md
# Display Interrupt and Frame-Synchronous Register Unit

This unit sits beside a display controller's pixel path. Software programs a set of control registers and a mask register through a simple write port. Control writes land in a shadow copy and reach the controller only when the frame in progress finishes. At that boundary a register-update event is raised, but only if some control value was written since the last transfer. The unit also watches the controller's enable input. When enable is withdrawn, the display keeps running until the current frame ends, and only then is a disable-done event raised. A pulse from the pixel FIFO reporting an underrun raises a third event.

Each event sets a sticky status bit, and software clears a bit by writing one to it. A mask bit set to 1 hides the matching event from the single level-sensitive interrupt line. The enable sequencer is a three-state machine. SEQ_IDLE means the display is off. SEQ_RUN means the display is on and enabled. SEQ_DRAIN means enable has been withdrawn and the unit is waiting for the frame to end. The transitions are as follows:
- IDLE to RUN when enable is high.
- RUN to DRAIN when enable drops with no frame end.
- RUN to IDLE when enable drops in the same cycle as a frame end.
- DRAIN to IDLE on a frame end, whatever enable is.
- DRAIN to RUN when enable returns before a frame end.

Top module: `disp_irq_unit`

## Requirements
- R1: After reset the status bits are 0, all three mask bits are 1, the interrupt line is low, every active control value is 0 and the display-on output is low.
- R2: A write to address k (0 to NUM_CTRL-1) updates only the shadow copy of control register k. The active output for register k changes only in the cycle after a frame-end pulse. It then takes the shadow value held before that cycle's write.
- R3: The display-on output rises in the cycle after enable is sampled high in SEQ_IDLE. It stays high in SEQ_RUN and SEQ_DRAIN.
- R4: Status bit 0 (disable done) sets, and display-on falls, in the cycle after a frame-end pulse seen in SEQ_DRAIN, or in SEQ_RUN with enable low. If enable returns before the frame ends, the bit is not set.
- R5: Status bit 1 (register update) sets on a frame-end pulse only if a control write occurred since the previous transfer. A control write in the same cycle as the frame end stays pending for the next frame end.
- R6: Status bit 2 (FIFO underrun) sets in the cycle after an underrun pulse.
- R7: Writing to address NUM_CTRL+1 clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. A new event in the same cycle as its clear keeps the bit set.
- R8: Address NUM_CTRL holds the mask in data bits 2:0, with the same bit order as status. The interrupt line is high exactly when some status bit is set and its mask bit is 0.
- R9: Writes to addresses above NUM_CTRL+1 change no output and leave no update pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Display enable requested by software |
| frame_end | input | 1 | One-cycle pulse when the frame being shown finishes |
| fifo_urun | input | 1 | One-cycle pulse when the pixel FIFO runs dry |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register write address |
| bus_wdata | input | DATA_W | Register write data |
| disp_on | output | 1 | Display is running (sequencer not idle) |
| ctrl_active | output | NUM_CTRL*DATA_W | Active control values, register k in bits k*DATA_W upward |
| irq_status | output | 3 | Sticky status: bit 0 disable done, bit 1 register update, bit 2 underrun |
| irq | output | 1 | Level interrupt request |

## Verification
A sequencer stuck in the wrong state shows on disp_on one cycle after the enable or frame-end input that should have moved it. The same fault shows as a missing or extra disable-done bit on the next frame end. A lost or stuck pending flag shows up on the first frame end that follows, as a wrong register-update bit or an active value that does not move. A corrupted mask or status bit reaches irq and irq_status in the same cycle it happens. For that reason the bench compares every output against its model on every clock.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

    localparam int NUM_EVT = 3;
    localparam int EVT_DD  = 0;
    localparam int EVT_RU  = 1;
    localparam int EVT_FU  = 2;

endpackage

// File: rtl/disp_irq_seq.sv
module disp_irq_seq
    import disp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_en,
    input  logic frame_end,
    output logic disp_on,
    output logic dd_evt
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        dd_evt  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (ctrl_en) begin
                    state_d = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (!ctrl_en) begin
                    if (frame_end) begin
                        state_d = SEQ_IDLE;
                        dd_evt  = 1'b1;
                    end else begin
                        state_d = SEQ_DRAIN;
                    end
                end
            end
            SEQ_DRAIN: begin
                if (frame_end) begin
                    state_d = SEQ_IDLE;
                    dd_evt  = 1'b1;
                end else if (ctrl_en) begin
                    state_d = SEQ_RUN;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
            end
        endcase
    end

    assign disp_on = (state_q != SEQ_IDLE);

endmodule

// File: rtl/disp_irq_shadow_bank.sv
module disp_irq_shadow_bank #(
    parameter int DATA_W   = 16,
    parameter int NUM_CTRL = 4,
    parameter int ADDR_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       frame_end,
    output logic [NUM_CTRL*DATA_W-1:0] active_flat,
    output logic                       ru_evt
);

    logic [NUM_CTRL-1:0] hit;
    logic                pend_q;
    logic                apply;

    assign apply = frame_end && pend_q;

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
        logic [DATA_W-1:0] shadow_q;
        logic [DATA_W-1:0] active_q;

        assign hit[g] = wr_en && (wr_addr == ADDR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
                active_q <= '0;
            end else begin
                if (hit[g]) begin
                    shadow_q <= wr_data;
                end
                if (apply) begin
                    active_q <= shadow_q;
                end
            end
        end

        assign active_flat[g*DATA_W +: DATA_W] = active_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (|hit) begin
            pend_q <= 1'b1;
        end else if (frame_end) begin
            pend_q <= 1'b0;
        end
    end

    assign ru_evt = apply;

endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
    import disp_irq_pkg::*;
#(
    parameter int NUM_CTRL = 4,
    parameter int ADDR_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NUM_EVT-1:0] wr_bits,
    input  logic [NUM_EVT-1:0] evt,
    output logic [NUM_EVT-1:0] status,
    output logic               irq
);

    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_CTRL);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CTRL + 1);

    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] stat_q;
    logic [NUM_EVT-1:0] clr;

    assign clr = (wr_en && wr_addr == STAT_ADDR) ? wr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en && wr_addr == MASK_ADDR) begin
            mask_q <= wr_bits;
        end
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[e] <= 1'b0;
            end else if (evt[e]) begin
                stat_q[e] <= 1'b1;
            end else if (clr[e]) begin
                stat_q[e] <= 1'b0;
            end
        end
    end

    assign status = stat_q;
    assign irq    = |(stat_q & ~mask_q);

endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit
    import disp_irq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_CTRL = 4,
    parameter int ADDR_W   = $clog2(NUM_CTRL + 2)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctrl_en,
    input  logic                       frame_end,
    input  logic                       fifo_urun,
    input  logic                       bus_wr_en,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic                       disp_on,
    output logic [NUM_CTRL*DATA_W-1:0] ctrl_active,
    output logic [NUM_EVT-1:0]         irq_status,
    output logic                       irq
);

    logic dd_evt;
    logic ru_evt;
    logic [NUM_EVT-1:0] evt;

    disp_irq_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_en   (ctrl_en),
        .frame_end (frame_end),
        .disp_on   (disp_on),
        .dd_evt    (dd_evt)
    );

    disp_irq_shadow_bank #(
        .DATA_W   (DATA_W),
        .NUM_CTRL (NUM_CTRL),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr_en),
        .wr_addr     (bus_addr),
        .wr_data     (bus_wdata),
        .frame_end   (frame_end),
        .active_flat (ctrl_active),
        .ru_evt      (ru_evt)
    );

    always_comb begin
        evt         = '0;
        evt[EVT_DD] = dd_evt;
        evt[EVT_RU] = ru_evt;
        evt[EVT_FU] = fifo_urun;
    end

    disp_irq_status #(
        .NUM_CTRL (NUM_CTRL),
        .ADDR_W   (ADDR_W)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .wr_addr (bus_addr),
        .wr_bits (bus_wdata[NUM_EVT-1:0]),
        .evt     (evt),
        .status  (irq_status),
        .irq     (irq)
    );

endmodule

// File: rtl/disp_irq_unit_chk.sv
module disp_irq_unit_chk #(
    parameter int DATA_W   = 16,
    parameter int NUM_CTRL = 4,
    parameter int ADDR_W   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ctrl_en,
    input logic                       frame_end,
    input logic                       fifo_urun,
    input logic                       bus_wr_en,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       ru_clr_bit,
    input logic                       disp_on,
    input logic [NUM_CTRL*DATA_W-1:0] ctrl_active,
    input logic [2:0]                 irq_status,
    input logic                       irq
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CTRL + 1);

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(ctrl_active)); // R2

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_on && !ctrl_en) |=> !disp_on); // R3

    AST_DD_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[0]) |-> ($past(frame_end) && $past(disp_on))); // R4

    AST_FU_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_urun |=> irq_status[2]); // R6

    AST_RU_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[1] && !(bus_wr_en && bus_addr == STAT_ADDR && ru_clr_bit))
        |=> irq_status[1]); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status == 3'b000) |-> !irq); // R8

endmodule

bind disp_irq_unit disp_irq_unit_chk #(
    .DATA_W   (DATA_W),
    .NUM_CTRL (NUM_CTRL),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_en     (ctrl_en),
    .frame_end   (frame_end),
    .fifo_urun   (fifo_urun),
    .bus_wr_en   (bus_wr_en),
    .bus_addr    (bus_addr),
    .ru_clr_bit  (bus_wdata[1]),
    .disp_on     (disp_on),
    .ctrl_active (ctrl_active),
    .irq_status  (irq_status),
    .irq         (irq)
);

// File: tb/disp_irq_unit_tb.sv
module disp_irq_unit_tb;

    localparam int DW = 16;
    localparam int NC = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_en = 1'b0;
    logic          frame_end = 1'b0;
    logic          fifo_urun = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          disp_on;
    logic [NC*DW-1:0] ctrl_active;
    logic [2:0]    irq_status;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_state;
    int m_pend;
    int m_mask;
    int m_stat;
    int m_shadow[NC];
    int m_active[NC];

    always #5 clk = ~clk;

    disp_irq_unit #(.DATA_W(DW), .NUM_CTRL(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .frame_end(frame_end),
        .fifo_urun(fifo_urun), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .disp_on(disp_on), .ctrl_active(ctrl_active),
        .irq_status(irq_status), .irq(irq)
    );

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_pend = 0; m_mask = 7; m_stat = 0;
            for (int i = 0; i < NC; i++) begin
                m_shadow[i] = 0; m_active[i] = 0;
            end
        end else begin
            int dd, ru, clr, a;
            dd = 0;
            a  = int'(bus_addr);
            case (m_state)
                0: if (ctrl_en) m_state = 1;
                1: if (!ctrl_en) begin
                       if (frame_end) begin m_state = 0; dd = 1; end
                       else m_state = 2;
                   end
                default: if (frame_end) begin m_state = 0; dd = 1; end
                         else if (ctrl_en) m_state = 1;
            endcase
            ru = (frame_end && m_pend != 0) ? 1 : 0;
            if (ru != 0)
                for (int i = 0; i < NC; i++) m_active[i] = m_shadow[i];
            if (bus_wr_en && a < NC) begin
                m_shadow[a] = int'(bus_wdata);
                m_pend = 1;
            end else if (frame_end) begin
                m_pend = 0;
            end
            if (bus_wr_en && a == NC) m_mask = int'(bus_wdata) & 7;
            clr = (bus_wr_en && a == NC + 1) ? (int'(bus_wdata) & 7) : 0;
            m_stat = (m_stat & ~clr) | dd | (ru << 1) | (int'(fifo_urun) << 2);
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3 disp_on", int'(disp_on), (m_state != 0) ? 1 : 0);
        for (int i = 0; i < NC; i++)
            chk("R2 ctrl_active", int'(ctrl_active[i*DW +: DW]), m_active[i]);
        chk("R4 status_dd", int'(irq_status[0]), m_stat & 1);
        chk("R5 status_ru", int'(irq_status[1]), (m_stat >> 1) & 1);
        chk("R6 status_fu", int'(irq_status[2]), (m_stat >> 2) & 1);
        chk("R8 irq", int'(irq), ((m_stat & ~m_mask & 7) != 0) ? 1 : 0);
    endtask

    // Drive one cycle at the falling edge, then compare at the next one
    task automatic cyc(bit en, bit fe, bit fu, bit wr, int addr, int data);
        ctrl_en   = en;
        frame_end = fe;
        fifo_urun = fu;
        bus_wr_en = wr;
        bus_addr  = AW'(addr);
        bus_wdata = DW'(data);
        @(posedge clk);
        @(negedge clk);
        frame_end = 0; fifo_urun = 0; bus_wr_en = 0;
        compare_all();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", int'(irq_status), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 disp_on", int'(disp_on), 0);
        chk("R1 active", (ctrl_active == '0) ? 1 : 0, 1);
        rst_n = 1;
        cyc(0, 0, 0, 0, 0, 0);

        // R6 underrun sets its bit; R1 reset mask hides it
        cyc(0, 0, 1, 0, 0, 0);
        chk("R6 fu set", int'(irq_status[2]), 1);
        chk("R1 mask reset", int'(irq), 0);
        // R8 unmask all
        cyc(0, 0, 0, 1, NC, 0);
        chk("R8 unmasked irq", int'(irq), 1);
        // R7 writing 0 keeps, writing 1 clears
        cyc(0, 0, 0, 1, NC + 1, 3);
        chk("R7 zero keeps", int'(irq_status[2]), 1);
        cyc(0, 0, 0, 1, NC + 1, 4);
        chk("R7 one clears", int'(irq_status[2]), 0);

        // R2 shadow writes stay hidden until frame end
        for (int i = 0; i < NC; i++) cyc(0, 0, 0, 1, i, 16'h1100 + i);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R2 hidden", int'(ctrl_active[DW-1:0]), 0);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R2 applied", int'(ctrl_active[DW +: DW]), 16'h1101);
        chk("R5 ru set", int'(irq_status[1]), 1);
        cyc(0, 0, 0, 1, NC + 1, 2);
        // R5 no write, no update event
        cyc(0, 1, 0, 0, 0, 0);
        chk("R5 no write", int'(irq_status[1]), 0);
        // R5 write in the frame-end cycle stays pending
        cyc(0, 1, 0, 1, 2, 16'hBEEF);
        chk("R5 same-cycle old", int'(ctrl_active[2*DW +: DW]), 16'h1102);
        cyc(0, 0, 0, 1, NC + 1, 2);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R5 pending applied", int'(ctrl_active[2*DW +: DW]), 16'hBEEF);
        chk("R5 pending ru", int'(irq_status[1]), 1);
        cyc(0, 0, 0, 1, NC + 1, 7);

        // R3 / R4 enable, run, drain, disable done
        cyc(1, 0, 0, 0, 0, 0);
        chk("R3 on", int'(disp_on), 1);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R4 draining", int'(disp_on), 1);
        chk("R4 no early dd", int'(irq_status[0]), 0);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R4 dd set", int'(irq_status[0]), 1);
        chk("R4 off", int'(disp_on), 0);
        cyc(0, 0, 0, 1, NC + 1, 1);
        // R4 re-enable before frame end cancels
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R4 cancelled", int'(irq_status[0]), 0);
        // R4 enable low in frame-end cycle from RUN
        cyc(0, 1, 0, 0, 0, 0);
        chk("R4 direct dd", int'(irq_status[0]), 1);

        // R7 clear and new event together: event wins
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 1, NC + 1, 4);
        chk("R7 event wins", int'(irq_status[2]), 1);
        // R8 mask all but disable done; only FU left set
        cyc(0, 0, 0, 1, NC + 1, 1);
        cyc(0, 0, 0, 1, NC, 6);
        chk("R8 masked", int'(irq), 0);

        // R9 out-of-range writes ignored
        cyc(0, 0, 0, 1, NC + 2, 16'hFFFF);
        cyc(0, 0, 0, 1, NC + 3, 16'hFFFF);
        chk("R9 status", int'(irq_status), 4);
        cyc(0, 0, 0, 1, NC, 0);
        cyc(0, 0, 0, 1, NC + 1, 4);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R9 no pending", int'(irq_status[1]), 0);
        chk("R9 active", int'(ctrl_active[DW-1:0]), 16'h1100);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule